// File: doc/BRIEF.md
# Instruction-Set Switch Jump Unit

This execute-stage block performs the jump that moves a core out of its legacy 32-bit instruction set and into its native 64-bit instruction set. A request carries a one-cycle snapshot of everything the jump needs:

- the environment mode and the privilege level;
- the transition-disable and taken-branch-trap status bits;
- a pending floating-point error flag;
- the jump form and operand size;
- the displacement and the indirect operand value;
- the code-segment base and the next sequential legacy instruction pointer.

The block resolves the request into a single outcome, chosen by a fixed priority. If a fault or an environment termination wins, nothing architectural is written. If the jump commits, the block produces a 16-byte aligned, zero-extended 64-bit target. It also produces a zero-extended return address for the general-register writeback and a pulse that clears the instruction-set, instruction-debug and resume status bits. A commit with branch trapping enabled is reported as a commit followed by a debug trap.

All results are registered. They appear on the cycle after the request and last for exactly one cycle.

Top module: `isj_jump_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, res_valid, ip_we, ret_we and status_clr are low, res_code is 0 (none), and ip_target and ret_value are zero.
- R2: res_valid is high exactly in the cycle after a cycle with req_valid high. res_code is 0 in every cycle without a result.
- R3: When env_native is 0, the outcome is 1 (terminate) at privilege level 0 and 2 (illegal opcode) at levels 1 to 3, whatever the other status inputs are.
- R4: When env_native is 1 and st_dis_trans is 1, the outcome is 3 (disabled transition), whatever fp_pending and st_br_trap are.
- R5: When env_native is 1, st_dis_trans is 0 and fp_pending is 1, the outcome is 4 (floating-point error).
- R6: On commit, ip_target[31:0] is the selected source plus cs_base modulo 2^32, with bits 3:0 forced to zero. The source is the displacement when form_ind is 0 and the operand when form_ind is 1. ip_target[63:32] is zero, and ip_we is high.
- R7: On commit, ret_value[31:0] equals next_ip plus cs_base modulo 2^32, ret_value[63:32] is zero, and ret_we is high.
- R8: On commit, status_clr is high for the result cycle. It requests clearing of the instruction-set, instruction-debug and resume bits.
- R9: A commit gives outcome 5 when st_br_trap is 0 and outcome 6 (commit with debug trap) when it is 1. The writes of R6 to R8 happen in both cases.
- R10: On outcomes 1 to 4, and in cycles without a result, ip_we, ret_we and status_clr are low and ip_target and ret_value are zero.
- R11: When op_wide is 0, only bits 15:0 of the selected source are used, zero-extended to 32 bits. When op_wide is 1, all 32 bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Jump request this cycle |
| env_native | input | 1 | Native system environment active |
| priv_lvl | input | 2 | Current privilege level |
| st_dis_trans | input | 1 | Instruction-set transitions disabled |
| st_br_trap | input | 1 | Taken-branch trap enabled |
| fp_pending | input | 1 | Floating-point exceptions pending |
| form_ind | input | 1 | 1: indirect operand form, 0: absolute displacement form |
| op_wide | input | 1 | 1: 32-bit source, 0: 16-bit source |
| disp_val | input | 32 | Displacement |
| oper_val | input | 32 | Indirect operand value |
| cs_base | input | 32 | Code-segment base |
| next_ip | input | 32 | Next sequential legacy instruction pointer |
| res_valid | output | 1 | Result valid |
| res_code | output | 3 | 0 none, 1 terminate, 2 illegal, 3 disabled, 4 fp error, 5 commit, 6 commit+trap |
| ip_we | output | 1 | Instruction pointer write |
| ip_target | output | 64 | New instruction pointer |
| ret_we | output | 1 | Return register write |
| ret_value | output | 64 | Return register value |
| status_clr | output | 1 | Clear the instruction-set, debug and resume bits |

## Verification
The bench builds the block with its default parameters: a 64-bit native address, a 32-bit legacy address, a 16-bit short operand and 16-byte alignment. With these values the zero-extension of 16-bit sources, the carry-out wrap at 2^32 and the masking of the low four target bits are all exercised. Random requests mix every privilege level, status bit and operand. Directed cases cover the all-ones additions and every step of the priority chain.

// File: rtl/isj_pkg.sv
package isj_pkg;

  typedef enum logic [2:0] {
    OUT_NONE       = 3'd0,
    OUT_TERMINATE  = 3'd1,
    OUT_ILLEGAL    = 3'd2,
    OUT_DISABLED   = 3'd3,
    OUT_FP_ERROR   = 3'd4,
    OUT_COMMIT     = 3'd5,
    OUT_COMMIT_TRP = 3'd6
  } isj_outcome_e;

  function automatic logic isj_is_commit(isj_outcome_e o);
    return (o == OUT_COMMIT) || (o == OUT_COMMIT_TRP);
  endfunction

endpackage

// File: rtl/isj_outcome_arb.sv
module isj_outcome_arb
  import isj_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic              env_native,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              st_dis_trans,
  input  logic              st_br_trap,
  input  logic              fp_pending,
  output isj_outcome_e      outcome
);

  localparam logic [PRIV_W-1:0] KERNEL_LVL = '0;

  // Fixed priority: environment, disabled transition, fp error, commit.
  always_comb begin
    if (!env_native) begin
      outcome = (priv_lvl == KERNEL_LVL) ? OUT_TERMINATE : OUT_ILLEGAL;
    end else if (st_dis_trans) begin
      outcome = OUT_DISABLED;
    end else if (fp_pending) begin
      outcome = OUT_FP_ERROR;
    end else if (st_br_trap) begin
      outcome = OUT_COMMIT_TRP;
    end else begin
      outcome = OUT_COMMIT;
    end
  end

endmodule

// File: rtl/isj_target_calc.sv
module isj_target_calc #(
  parameter int VA_W     = 64,
  parameter int LEG_W    = 32,
  parameter int SHORT_W  = 16,
  parameter int ALIGN_LG = 4
) (
  input  logic             form_ind,
  input  logic             op_wide,
  input  logic [LEG_W-1:0] disp_val,
  input  logic [LEG_W-1:0] oper_val,
  input  logic [LEG_W-1:0] cs_base,
  input  logic [LEG_W-1:0] next_ip,
  output logic [VA_W-1:0]  target,
  output logic [VA_W-1:0]  ret_addr
);

  localparam int EXT_W = VA_W - LEG_W;
  localparam logic [LEG_W-1:0] LOW_ONES   = LEG_W'((64'd1 << ALIGN_LG) - 64'd1);
  localparam logic [LEG_W-1:0] ALIGN_MASK = ~LOW_ONES;

  logic [LEG_W-1:0] src;
  logic [LEG_W-1:0] src_ext;
  logic [LEG_W-1:0] tgt_sum;
  logic [LEG_W-1:0] ret_sum;

  assign src = form_ind ? oper_val : disp_val;

  generate
    if (SHORT_W < LEG_W) begin : g_short
      assign src_ext = op_wide ? src : {{(LEG_W-SHORT_W){1'b0}}, src[SHORT_W-1:0]};
    end else begin : g_full
      assign src_ext = src;
    end
  endgenerate

  // Additions wrap at the legacy width.
  assign tgt_sum  = src_ext + cs_base;
  assign ret_sum  = next_ip + cs_base;
  assign target   = {{EXT_W{1'b0}}, tgt_sum & ALIGN_MASK};
  assign ret_addr = {{EXT_W{1'b0}}, ret_sum};

endmodule

// File: rtl/isj_jump_unit.sv
module isj_jump_unit
  import isj_pkg::*;
#(
  parameter int VA_W     = 64,
  parameter int LEG_W    = 32,
  parameter int SHORT_W  = 16,
  parameter int ALIGN_LG = 4,
  parameter int PRIV_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              env_native,
  input  logic [PRIV_W-1:0] priv_lvl,
  input  logic              st_dis_trans,
  input  logic              st_br_trap,
  input  logic              fp_pending,
  input  logic              form_ind,
  input  logic              op_wide,
  input  logic [LEG_W-1:0]  disp_val,
  input  logic [LEG_W-1:0]  oper_val,
  input  logic [LEG_W-1:0]  cs_base,
  input  logic [LEG_W-1:0]  next_ip,
  output logic              res_valid,
  output logic [2:0]        res_code,
  output logic              ip_we,
  output logic [VA_W-1:0]   ip_target,
  output logic              ret_we,
  output logic [VA_W-1:0]   ret_value,
  output logic              status_clr
);

  localparam int EXT_W = VA_W - LEG_W;

  isj_outcome_e     outcome;
  logic [VA_W-1:0]  tgt_c;
  logic [VA_W-1:0]  ret_c;
  logic             commit_c;

  isj_outcome_arb #(.PRIV_W(PRIV_W)) u_arb (
    .env_native  (env_native),
    .priv_lvl    (priv_lvl),
    .st_dis_trans(st_dis_trans),
    .st_br_trap  (st_br_trap),
    .fp_pending  (fp_pending),
    .outcome     (outcome)
  );

  isj_target_calc #(
    .VA_W(VA_W), .LEG_W(LEG_W), .SHORT_W(SHORT_W), .ALIGN_LG(ALIGN_LG)
  ) u_calc (
    .form_ind(form_ind),
    .op_wide (op_wide),
    .disp_val(disp_val),
    .oper_val(oper_val),
    .cs_base (cs_base),
    .next_ip (next_ip),
    .target  (tgt_c),
    .ret_addr(ret_c)
  );

  assign commit_c = req_valid && isj_is_commit(outcome);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_code   <= OUT_NONE;
      ip_we      <= 1'b0;
      ip_target  <= '0;
      ret_we     <= 1'b0;
      ret_value  <= '0;
      status_clr <= 1'b0;
    end else begin
      res_valid  <= req_valid;
      res_code   <= req_valid ? outcome : OUT_NONE;
      ip_we      <= commit_c;
      ret_we     <= commit_c;
      status_clr <= commit_c;
      ip_target  <= commit_c ? tgt_c : '0;
      ret_value  <= commit_c ? ret_c : '0;
    end
  end

  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  a_r2_idle_no_result: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!res_valid && res_code == 3'd0));
  a_r3_kernel_terminates: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !env_native && priv_lvl == '0) |=> res_code == 3'd1);
  a_r4_disabled_priority: assert property (@(posedge clk) disable iff (rst)
    (req_valid && env_native && st_dis_trans) |=> res_code == 3'd3);
  a_r6_target_shape: assert property (@(posedge clk) disable iff (rst)
    ip_we |-> (ip_target[ALIGN_LG-1:0] == '0 && ip_target[VA_W-1:LEG_W] == {EXT_W{1'b0}}));
  a_r7_ret_upper_zero: assert property (@(posedge clk) disable iff (rst)
    ret_we |-> ret_value[VA_W-1:LEG_W] == {EXT_W{1'b0}});
  a_r10_no_write_on_fault: assert property (@(posedge clk) disable iff (rst)
    (res_code < 3'd5) |-> (!ip_we && !ret_we && !status_clr));

endmodule

// File: tb/isj_jump_unit_tb.sv
module isj_jump_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        env_native;
  logic [1:0]  priv_lvl;
  logic        st_dis_trans, st_br_trap, fp_pending, form_ind, op_wide;
  logic [31:0] disp_val, oper_val, cs_base, next_ip;
  logic        res_valid, ip_we, ret_we, status_clr;
  logic [2:0]  res_code;
  logic [63:0] ip_target, ret_value;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  isj_jump_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .env_native(env_native),
    .priv_lvl(priv_lvl), .st_dis_trans(st_dis_trans), .st_br_trap(st_br_trap),
    .fp_pending(fp_pending), .form_ind(form_ind), .op_wide(op_wide),
    .disp_val(disp_val), .oper_val(oper_val), .cs_base(cs_base), .next_ip(next_ip),
    .res_valid(res_valid), .res_code(res_code), .ip_we(ip_we), .ip_target(ip_target),
    .ret_we(ret_we), .ret_value(ret_value), .status_clr(status_clr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code();
    if (!env_native) return (priv_lvl == 2'd0) ? 3'd1 : 3'd2;
    if (st_dis_trans) return 3'd3;
    if (fp_pending) return 3'd4;
    return st_br_trap ? 3'd6 : 3'd5;
  endfunction

  function automatic logic [63:0] exp_target();
    logic [31:0] s;
    s = form_ind ? oper_val : disp_val;
    if (!op_wide) s = {16'h0, s[15:0]};
    s = s + cs_base;
    return {32'h0, s[31:4], 4'h0};
  endfunction

  function automatic logic [63:0] exp_ret();
    logic [31:0] s;
    s = next_ip + cs_base;
    return {32'h0, s};
  endfunction

  task automatic check_idle(input string tag);
    check(res_valid == 1'b0 && res_code == 3'd0, {tag, " R2 idle"}, {61'h0, res_code}, 64'h0);
    check(!ip_we && !ret_we && !status_clr && ip_target == 64'h0 && ret_value == 64'h0,
          {tag, " R10 idle writes"}, ip_target, 64'h0);
  endtask

  // Called at a negedge with inputs applied; checks results at the next negedge.
  task automatic run_req();
    logic [2:0]  c;
    logic [63:0] t, r;
    bit          cm;
    c  = exp_code();
    t  = exp_target();
    r  = exp_ret();
    cm = (c >= 3'd5);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(res_valid == 1'b1, "R2 valid", {63'h0, res_valid}, 64'h1);
    check(res_code == c, "R3 R4 R5 R9 code", {61'h0, res_code}, {61'h0, c});
    if (cm) begin
      check(ip_we && ip_target == t, "R6 R11 target", ip_target, t);
      check(ret_we && ret_value == r, "R7 return", ret_value, r);
      check(status_clr == 1'b1, "R8 status clear", {63'h0, status_clr}, 64'h1);
    end else begin
      check(!ip_we && !ret_we && !status_clr && ip_target == 64'h0 && ret_value == 64'h0,
            "R10 no write on fault", ip_target, 64'h0);
    end
  endtask

  task automatic rand_inputs();
    env_native   = ($urandom % 4) != 0;
    priv_lvl     = 2'($urandom);
    st_dis_trans = ($urandom % 5) == 0;
    fp_pending   = ($urandom % 5) == 0;
    st_br_trap   = 1'($urandom);
    form_ind     = 1'($urandom);
    op_wide      = 1'($urandom);
    disp_val     = $urandom;
    oper_val     = $urandom;
    cs_base      = $urandom;
    next_ip      = $urandom;
  endtask

  task automatic set_native(input bit dis, input bit fp, input bit trap);
    env_native = 1'b1; priv_lvl = 2'd3;
    st_dis_trans = dis; fp_pending = fp; st_br_trap = trap;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; req_valid = 1'b0;
    rand_inputs();
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");

    // R3 environment not native, every privilege level
    for (int p = 0; p < 4; p++) begin
      rand_inputs(); env_native = 1'b0; priv_lvl = 2'(p);
      st_dis_trans = 1'b1; fp_pending = 1'b1;
      run_req();
    end
    // R4 disabled beats fp and trap; R5 fp beats commit
    rand_inputs(); set_native(1, 1, 1); run_req();
    rand_inputs(); set_native(0, 1, 1); run_req();
    // R9 commit with and without trap
    rand_inputs(); set_native(0, 0, 0); run_req();
    rand_inputs(); set_native(0, 0, 1); run_req();
    // R6 R7 wrap at 2^32, absolute 32-bit
    set_native(0, 0, 0); form_ind = 0; op_wide = 1;
    disp_val = 32'hFFFF_FFFF; oper_val = 32'h0; cs_base = 32'h0000_0011; next_ip = 32'hFFFF_FFF0;
    run_req();
    // R11 16-bit indirect: upper bits ignored
    set_native(0, 0, 0); form_ind = 1; op_wide = 0;
    disp_val = 32'h0; oper_val = 32'hABCD_FFFF; cs_base = 32'h0000_0001; next_ip = 32'h1234_5678;
    run_req();
    // R11 16-bit absolute
    set_native(0, 0, 1); form_ind = 0; op_wide = 0;
    disp_val = 32'h7777_1239; oper_val = 32'hFFFF_FFFF; cs_base = 32'h1000_0000; next_ip = 32'h0;
    run_req();
    @(negedge clk);
    check_idle("R2 gap");

    // Random mix, with idle gaps
    for (int i = 0; i < 3000; i++) begin
      rand_inputs();
      run_req();
      if (($urandom % 4) == 0) begin
        @(negedge clk);
        check_idle("R2 random gap");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule